// File: doc/BRIEF.md
# Wake-up frame pattern matcher

This block sits beside a receive MAC and inspects every incoming frame for wake-up events while the rest of the system sleeps. Frames arrive one byte per qualified cycle, with markers on the first and last byte and a good-frame flag that accompanies the last byte. Four independent pattern slots each fold a chosen subset of the first 64 frame bytes into a CRC-32 signature. The subset comes from a per-slot byte mask. At the end of the frame each slot compares its signature against a programmed value.

A separate detector looks for a magic packet addressed to the station's MAC address. Every hit sets a sticky status bit. The logical OR of the status bits forms a single wake-up request.

Software programs the enables, the masks, the expected signatures and the MAC address through a small word-wide register port. Read data returns one cycle after the address is presented. Status bits are cleared by writing ones to them.

Top module: `wake_frame_matcher`

## Requirements
- R1: The control word at address 0 holds the four slot enables in bits 3..0 and the magic-packet enable in bit 7. It resets to zero. All other bits ignore writes and read as zero.
- R2: A slot, or the magic detector, whose enable bit is clear never sets its status bit, whatever the frame contents.
- R3: A slot signature is CRC-32 with polynomial 0x04C11DB7. Bits are fed least significant first, the register is preset to all ones at frame start, and the final value is inverted. Only mask-selected bytes enter the CRC. The slot matches when the signature equals its expected value, including on frames shorter than the mask.
- R4: Mask bit i selects frame byte i, counted from the first byte, for i below 64. Bytes at position 64 and beyond never affect any signature.
- R5: Hits are taken only on the last byte of a frame, and only when the good flag is high with that byte. A frame ending with the flag low sets nothing.
- R6: A magic packet is six 0xFF bytes followed directly by sixteen copies of the 48-bit station address, sent first byte first. The address occupies words 2..4. Each word holds the earlier byte in bits 7..0 and the later byte in bits 15..8.
- R7: Any mismatching byte restarts the magic search, so a sequence with fewer than sixteen copies sets nothing. A complete sequence later in the same frame still hits.
- R8: Status bits 3..0 (slots) and bit 4 (magic) are sticky. They become visible on the clock edge that takes the last frame byte and read back at address 1. Writing a one to a bit at address 1 clears it. wake_req equals the OR of the status bits.
- R9: Slot s uses the words starting at 8+8s: +0 is the expected CRC bits 15..0, +1 is bits 31..16, and +2..+5 are mask words. Mask word w holds mask bits 16w..16w+15. All of these reset to zero.
- R10: Cycles with rx_valid low are ignored, so idle gaps inside a frame do not change any result.
- R11: All enabled slots evaluate every frame independently, so one frame can set several slot bits at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte qualifier |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_good | input | 1 | Frame good, sampled with the last byte |
| rx_data | input | 8 | Received byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address (read and write) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data, one cycle after address |
| wake_status | output | 5 | Sticky hits: slots in 3..0, magic in 4 |
| wake_req | output | 1 | OR of all status bits |

## Verification
The bench uses the default build: four slots, a 64-byte mask window and a 6-bit address. With these settings, 80-byte frames carry bytes past the mask window, so the bench can show that those bytes are excluded. Magic frames of about 120 bytes fit the full 96-byte address run after a header, and also fit a broken first attempt followed by a good one. The bench computes every expected signature with an MSB-first CRC on bit-reversed data. This is an independent form of the same code as the design's reflected shift.

// File: rtl/wfm_pkg.sv
package wfm_pkg;

  // Register word map; slot blocks are laid out at a fixed stride
  localparam int REG_CTRL       = 0;
  localparam int REG_STAT       = 1;
  localparam int REG_MAC        = 2;
  localparam int MAC_WORDS      = 3;
  localparam int SLOT_BASE      = 8;
  localparam int SLOT_STRIDE    = 8;
  localparam int CTRL_MAGIC_BIT = 7;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;

  typedef enum logic {MG_SYNC, MG_ADDR} magic_phase_e;

  function automatic int slot_base(input int s);
    return SLOT_BASE + SLOT_STRIDE * s;
  endfunction

  // One byte of reflected CRC-32, least significant bit first
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/wfm_regs.sv
module wfm_regs #(
  parameter int NUM_SLOTS  = 4,
  parameter int MASK_BYTES = 64,
  parameter int ADDR_W     = 6
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [15:0]                           wdata,
  input  logic [NUM_SLOTS:0]                    status,
  output logic [15:0]                           rdata,
  output logic [NUM_SLOTS-1:0]                  slot_en,
  output logic                                  magic_en,
  output logic [47:0]                           mac,
  output logic [NUM_SLOTS-1:0][31:0]            exp_crc,
  output logic [NUM_SLOTS-1:0][MASK_BYTES-1:0]  mask,
  output logic [NUM_SLOTS:0]                    clr
);
  import wfm_pkg::*;

  localparam int MASK_WORDS = MASK_BYTES / 16;

  logic [31:0] a;
  logic [15:0] rd_next;

  assign a = 32'(addr);

  // R1 R9: writable fields; reserved control bits have no storage
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_en  <= '0;
      magic_en <= 1'b0;
      mac      <= '0;
      exp_crc  <= '0;
      mask     <= '0;
    end else if (wr) begin
      if (a == REG_CTRL) begin
        slot_en  <= wdata[NUM_SLOTS-1:0];
        magic_en <= wdata[CTRL_MAGIC_BIT];
      end
      for (int k = 0; k < MAC_WORDS; k++)
        if (a == REG_MAC + k) mac[16*k +: 16] <= wdata;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (a == slot_base(s))     exp_crc[s][15:0]  <= wdata;
        if (a == slot_base(s) + 1) exp_crc[s][31:16] <= wdata;
        for (int w = 0; w < MASK_WORDS; w++)
          if (a == slot_base(s) + 2 + w) mask[s][16*w +: 16] <= wdata;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (a == REG_CTRL) begin
      rd_next[NUM_SLOTS-1:0]  = slot_en;
      rd_next[CTRL_MAGIC_BIT] = magic_en;
    end
    if (a == REG_STAT) rd_next[NUM_SLOTS:0] = status;
    for (int k = 0; k < MAC_WORDS; k++)
      if (a == REG_MAC + k) rd_next = mac[16*k +: 16];
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (a == slot_base(s))     rd_next = exp_crc[s][15:0];
      if (a == slot_base(s) + 1) rd_next = exp_crc[s][31:16];
      for (int w = 0; w < MASK_WORDS; w++)
        if (a == slot_base(s) + 2 + w) rd_next = mask[s][16*w +: 16];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R8: write-one-to-clear strobe toward the status register
  assign clr = (wr && a == REG_STAT) ? wdata[NUM_SLOTS:0] : '0;

endmodule

// File: rtl/wfm_crc_slot.sv
module wfm_crc_slot #(
  parameter int MASK_BYTES = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  vld,
  input  logic                  sof,
  input  logic                  eof,
  input  logic                  good,
  input  logic                  enable,
  input  logic [7:0]            data,
  input  logic [MASK_BYTES-1:0] mask,
  input  logic [31:0]           exp_crc,
  output logic                  hit
);
  import wfm_pkg::*;

  localparam int IDX_W = $clog2(MASK_BYTES + 1);
  localparam int MW    = $clog2(MASK_BYTES);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(MASK_BYTES);

  logic [IDX_W-1:0] idx_q, pos;
  logic [31:0]      crc_q, crc_base, crc_new;
  logic             in_win, sel;

  // R4: byte position saturates at the window edge
  assign pos      = sof ? '0 : idx_q;
  assign in_win   = pos < LIMIT;
  assign sel      = in_win && mask[pos[MW-1:0]];
  // R3: preset on first byte, fold only selected bytes
  assign crc_base = sof ? CRC_PRESET : crc_q;
  assign crc_new  = sel ? crc32_byte(crc_base, data) : crc_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= CRC_PRESET;
      idx_q <= '0;
    end else if (vld) begin   // R10
      crc_q <= crc_new;
      idx_q <= in_win ? pos + 1'b1 : pos;
    end
  end

  // R5 R2: decision on the last good byte, enabled slots only
  assign hit = vld && eof && good && enable && ((~crc_new) == exp_crc);

endmodule

// File: rtl/wfm_magic.sv
module wfm_magic (
  input  logic        clk,
  input  logic        rst,
  input  logic        vld,
  input  logic        sof,
  input  logic        eof,
  input  logic        good,
  input  logic        enable,
  input  logic [7:0]  data,
  input  logic [47:0] mac,
  output logic        hit
);
  import wfm_pkg::*;

  magic_phase_e ph_q, ph_b, ph_n;
  logic [2:0]   ff_q, ff_b, ff_n;
  logic [2:0]   bp_q, bp_b, bp_n;
  logic [3:0]   rep_q, rep_b, rep_n;
  logic         fnd_q, fnd_b, fnd_n;

  function automatic logic [7:0] mac_byte(input logic [47:0] m, input logic [2:0] i);
    case (i)
      3'd0:    return m[7:0];
      3'd1:    return m[15:8];
      3'd2:    return m[23:16];
      3'd3:    return m[31:24];
      3'd4:    return m[39:32];
      default: return m[47:40];
    endcase
  endfunction

  always_comb begin
    if (sof) begin
      ph_b = MG_SYNC; ff_b = '0; bp_b = '0; rep_b = '0; fnd_b = 1'b0;
    end else begin
      ph_b = ph_q; ff_b = ff_q; bp_b = bp_q; rep_b = rep_q; fnd_b = fnd_q;
    end
    ph_n = ph_b; ff_n = ff_b; bp_n = bp_b; rep_n = rep_b; fnd_n = fnd_b;
    if (ph_b == MG_SYNC) begin
      // R6: six 0xFF bytes, then the first address byte
      if (ff_b == 3'd6 && data == mac_byte(mac, 3'd0)) begin
        ph_n = MG_ADDR; bp_n = 3'd1; rep_n = '0; ff_n = '0;
      end else if (data == 8'hFF) begin
        if (ff_b != 3'd6) ff_n = ff_b + 3'd1;
      end else begin
        ff_n = '0;
      end
    end else begin
      if (data == mac_byte(mac, bp_b)) begin
        if (bp_b == 3'd5) begin
          bp_n = '0;
          if (rep_b == 4'd15) begin
            fnd_n = 1'b1; ph_n = MG_SYNC; ff_n = '0;
          end else begin
            rep_n = rep_b + 4'd1;
          end
        end else begin
          bp_n = bp_b + 3'd1;
        end
      end else begin
        // R7: restart, a 0xFF may begin a new sync run
        ph_n = MG_SYNC; bp_n = '0; rep_n = '0;
        ff_n = (data == 8'hFF) ? 3'd1 : 3'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= MG_SYNC; ff_q <= '0; bp_q <= '0; rep_q <= '0; fnd_q <= 1'b0;
    end else if (vld) begin
      ph_q <= ph_n; ff_q <= ff_n; bp_q <= bp_n; rep_q <= rep_n; fnd_q <= fnd_n;
    end
  end

  assign hit = vld && eof && good && enable && fnd_n;

endmodule

// File: rtl/wake_frame_matcher.sv
module wake_frame_matcher #(
  parameter int NUM_SLOTS  = 4,
  parameter int MASK_BYTES = 64,
  parameter int ADDR_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_good,
  input  logic [7:0]        rx_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [NUM_SLOTS:0] wake_status,
  output logic              wake_req
);
  logic [NUM_SLOTS-1:0]                 slot_en;
  logic                                 magic_en;
  logic [47:0]                          mac;
  logic [NUM_SLOTS-1:0][31:0]           exp_crc;
  logic [NUM_SLOTS-1:0][MASK_BYTES-1:0] mask;
  logic [NUM_SLOTS:0]                   clr_v, set_v, stat_n;

  wfm_regs #(.NUM_SLOTS(NUM_SLOTS), .MASK_BYTES(MASK_BYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status(wake_status), .rdata(reg_rdata), .slot_en(slot_en), .magic_en(magic_en),
    .mac(mac), .exp_crc(exp_crc), .mask(mask), .clr(clr_v)
  );

  // R11: one independent signature engine per slot
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    wfm_crc_slot #(.MASK_BYTES(MASK_BYTES)) u_slot (
      .clk(clk), .rst(rst), .vld(rx_valid), .sof(rx_sof), .eof(rx_eof),
      .good(rx_good), .enable(slot_en[s]), .data(rx_data), .mask(mask[s]),
      .exp_crc(exp_crc[s]), .hit(set_v[s])
    );
  end

  wfm_magic u_magic (
    .clk(clk), .rst(rst), .vld(rx_valid), .sof(rx_sof), .eof(rx_eof),
    .good(rx_good), .enable(magic_en), .data(rx_data), .mac(mac),
    .hit(set_v[NUM_SLOTS])
  );

  // R8: sticky status, a new hit wins over a clear in the same cycle
  assign stat_n = (wake_status & ~clr_v) | set_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_status <= '0;
      wake_req    <= 1'b0;
    end else begin
      wake_status <= stat_n;
      wake_req    <= |stat_n;
    end
  end

endmodule

// File: rtl/wfm_checker.sv
module wfm_checker #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rx_valid,
  input logic                 rx_eof,
  input logic                 rx_good,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [NUM_SLOTS:0]   clr_bits,
  input logic [15:0]          reg_rdata,
  input logic [NUM_SLOTS:0]   wake_status,
  input logic                 wake_req,
  input logic [NUM_SLOTS-1:0] slot_en,
  input logic                 magic_en
);
  localparam logic [15:0] CTRL_LIVE = 16'h0080 | 16'((1 << NUM_SLOTS) - 1);

  logic [NUM_SLOTS:0] clr;
  assign clr = (reg_wr && reg_addr == ADDR_W'(wfm_pkg::REG_STAT)) ? clr_bits : '0;

  assert_ctrl_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(wfm_pkg::REG_CTRL)) |=> ((reg_rdata & ~CTRL_LIVE) == 16'h0));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_off
    assert_disabled_slot_silent_R2: assert property (@(posedge clk) disable iff (rst)
      (!slot_en[s] && !wake_status[s]) |=> !wake_status[s]);
  end

  assert_disabled_magic_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (!magic_en && !wake_status[NUM_SLOTS]) |=> !wake_status[NUM_SLOTS]);

  assert_set_only_on_good_eof_R5: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_eof && rx_good) |=> ((wake_status & ~$past(wake_status)) == '0));

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((wake_status & $past(wake_status) & ~$past(clr)) ==
              ($past(wake_status) & ~$past(clr))));

  assert_req_is_or_R8: assert property (@(posedge clk) disable iff (rst)
    wake_req == (|wake_status));

endmodule

bind wake_frame_matcher wfm_checker #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof), .rx_good(rx_good),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .clr_bits(reg_wdata[NUM_SLOTS:0]),
  .reg_rdata(reg_rdata), .wake_status(wake_status), .wake_req(wake_req),
  .slot_en(slot_en), .magic_en(magic_en)
);

// File: tb/tb_wake_frame_matcher.sv
module tb_wake_frame_matcher;
  localparam int NS = 4;
  localparam int MB = 64;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst, rx_valid, rx_sof, rx_eof, rx_good, reg_wr, wake_req;
  logic [7:0] rx_data;
  logic [AW-1:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [NS:0] wake_status;

  wake_frame_matcher #(.NUM_SLOTS(NS), .MASK_BYTES(MB), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_good(rx_good), .rx_data(rx_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_status(wake_status),
    .wake_req(wake_req)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int kind_q[$];
  logic [15:0] val_q[$];
  string tag_q[$];

  logic [7:0] frm [0:255];
  int flen;
  logic [47:0] mac_v = 48'h5544_3322_1102;   // byte 0 = 0x02
  logic [63:0] m0 = 64'h0000_0000_0000_303F;
  logic [63:0] m1 = 64'h0000_01FF_FFF0_0000;
  logic [63:0] m2 = 64'hFFFF_FFFF_FFFF_FFFF;
  logic [63:0] m3 = 64'h00FF_00FF_00FF_00FF;
  logic [31:0] sg [0:3];

  // scoreboard monitor: compares queued expectations shortly after each falling edge
  initial forever begin
    int k;
    logic [15:0] v;
    string t;
    @(negedge clk);
    #1;
    while (kind_q.size() > 0) begin
      k = kind_q.pop_front(); v = val_q.pop_front(); t = tag_q.pop_front();
      n_vec++;
      if (k == 0) begin
        if (wake_status !== v[NS:0] || wake_req !== (v[NS:0] != 0)) begin
          n_bad++;
          $display("FAIL %s: status=%h req=%b expected status=%h req=%b",
                   t, wake_status, wake_req, v[NS:0], (v[NS:0] != 0));
        end
      end else if (reg_rdata !== v) begin
        n_bad++;
        $display("FAIL %s: rdata=%h expected %h", t, reg_rdata, v);
      end
    end
  end

  task automatic expect_status(input logic [15:0] e, input string t);
    kind_q.push_back(0); val_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [15:0] e, input string t);
    @(negedge clk); reg_addr = AW'(a);
    @(negedge clk);
    kind_q.push_back(1); val_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic send(input int len, input bit good, input int gap);
    for (int i = 0; i < len; i++) begin
      if (gap > 0 && i > 0 && (i % gap) == 0) begin
        @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_good = good && (i == len - 1); rx_data = frm[i];
    end
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
  endtask

  // MSB-first CRC on bit-reversed data, then reversed and inverted
  function automatic logic [31:0] ref_sig(input logic [63:0] m, input int len);
    logic [31:0] c;
    logic [31:0] r;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < len && i < 64; i++)
      if (m[i])
        for (int j = 0; j < 8; j++) begin
          logic fb;
          fb = c[31] ^ frm[i][j];
          c = {c[30:0], 1'b0};
          if (fb) c = c ^ 32'h04C1_1DB7;
        end
    for (int j = 0; j < 32; j++) r[j] = c[31 - j];
    return ~r;
  endfunction

  task automatic build_a();
    for (int i = 0; i < 80; i++) frm[i] = 8'((i * 37 + 11) % 256);
    flen = 80;
  endtask

  task automatic prog_slot(input int s, input logic [63:0] m, input logic [31:0] c);
    wr(8 + 8 * s, c[15:0]);
    wr(9 + 8 * s, c[31:16]);
    for (int w = 0; w < 4; w++) wr(10 + 8 * s + w, m[16 * w +: 16]);
  endtask

  task automatic build_magic(input int copies, input bit broken);
    int p;
    p = 0;
    for (int i = 0; i < 14; i++) begin frm[p] = 8'((i * 37 + 11) % 256); p++; end
    if (broken) begin
      for (int i = 0; i < 6; i++) begin frm[p] = 8'hFF; p++; end
      for (int i = 0; i < 12; i++) begin frm[p] = mac_v[8 * (i % 6) +: 8]; p++; end
      frm[p] = 8'h99; p++;
    end
    for (int i = 0; i < 6; i++) begin frm[p] = 8'hFF; p++; end
    for (int i = 0; i < 6 * copies; i++) begin frm[p] = mac_v[8 * (i % 6) +: 8]; p++; end
    for (int i = 0; i < 4; i++) begin frm[p] = 8'h00; p++; end
    flen = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
    rx_data = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    expect_status(16'h0000, "R8 reset status");
    rd(0, 16'h0000, "R1 reset control");
    rd(8, 16'h0000, "R9 reset crc low");
    rd(9, 16'h0000, "R9 reset crc high");
    rd(13, 16'h0000, "R9 reset mask word");

    wr(0, 16'hFFFF);
    rd(0, 16'h008F, "R1 reserved bits read zero");

    wr(2, 16'h1102); wr(3, 16'h3322); wr(4, 16'h5544);
    rd(3, 16'h3322, "R6 address word readback");

    build_a();
    sg[0] = ref_sig(m0, 80);
    sg[1] = ref_sig(m1, 80);
    sg[2] = ref_sig(m2, 80);
    sg[3] = ref_sig(m3, 80) ^ 32'h1;
    prog_slot(0, m0, sg[0]);
    prog_slot(1, m1, sg[1]);
    prog_slot(2, m2, sg[2]);
    prog_slot(3, m3, sg[3]);
    rd(8, sg[0][15:0], "R9 crc low word placement");
    rd(9, sg[0][31:16], "R9 crc high word placement");
    rd(19, m1[31:16], "R9 mask word placement");

    wr(0, 16'h000F);
    send(80, 1'b1, 0);
    expect_status(16'h0007, "R3 R4 R11 three slots match");
    rd(1, 16'h0007, "R8 status readback");
    wr(1, 16'h0001);
    expect_status(16'h0006, "R8 partial clear");
    wr(1, 16'h001F);
    expect_status(16'h0000, "R8 full clear");

    send(80, 1'b0, 0);
    expect_status(16'h0000, "R5 bad frame ignored");

    wr(0, 16'h000D);
    send(80, 1'b1, 0);
    expect_status(16'h0005, "R2 disabled slot silent");
    wr(1, 16'h001F);
    wr(0, 16'h000F);

    frm[30] = frm[30] ^ 8'h5A; frm[70] = frm[70] ^ 8'h33;
    send(80, 1'b1, 0);
    expect_status(16'h0001, "R3 masked byte change");
    wr(1, 16'h001F);

    build_a();
    frm[70] = frm[70] ^ 8'hA5; frm[75] = 8'h00; frm[64] = frm[64] ^ 8'h01;
    send(80, 1'b1, 0);
    expect_status(16'h0007, "R4 bytes past window excluded");
    wr(1, 16'h001F);

    build_a();
    send(80, 1'b1, 3);
    expect_status(16'h0007, "R10 idle gaps ignored");
    wr(1, 16'h001F);

    send(30, 1'b1, 0);
    expect_status(16'h0001, "R3 short frame");
    wr(1, 16'h001F);

    wr(0, 16'h0080);
    build_magic(16, 1'b0);
    send(flen, 1'b1, 5);
    expect_status(16'h0010, "R6 magic packet");
    rd(1, 16'h0010, "R8 magic status readback");
    wr(1, 16'h0010);
    expect_status(16'h0000, "R8 magic clear");

    build_magic(15, 1'b0);
    send(flen, 1'b1, 0);
    expect_status(16'h0000, "R7 fifteen copies");

    build_magic(16, 1'b1);
    send(flen, 1'b1, 0);
    expect_status(16'h0010, "R7 restart after mismatch");
    wr(1, 16'h001F);

    wr(0, 16'h0000);
    build_magic(16, 1'b0);
    send(flen, 1'b1, 0);
    expect_status(16'h0000, "R2 magic disabled");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule